// File: doc/BRIEF.md
# Scanline and Vertical-Blank Timing Generator

This block derives scanline timing from a fast system clock. The average number of clocks in one scanline does not need to be a whole number. The block holds that average as a fixed-point increment with a fractional part. Each scanline adds the increment to a small remainder register. The integer part of the sum sets the length of the next line in clocks, and the fractional bits carry over to the line after it. Over many lines the exact average is kept, and no single line is off by more than one clock.

The line-end ticks drive a scanline counter. The counter wraps at a frame length chosen by a standard-select input: 263 lines for the 60 Hz standard and 313 lines for the 50 Hz standard. When the counter reaches line 240, the block pulses a vertical-blank interrupt and advances a frame counter. From that line to the end of the frame, a blanking flag stays high. An odd/even field bit follows the frame counter, but only while both interlace mode bits are set. In every other mode the field bit is cleared at each vertical blank. A second divider gives an audio-update tick on every 32nd scanline, counted without a break across frame boundaries.

The increment, fraction width, line totals, blanking line, audio interval and counter widths are all parameters.

Top module: `scanline_timing_gen`

## Requirements
- R1: `hsync_tick` is high for one clock per scanline. Cycle 0 is the first cycle after reset is released. The n-th tick falls in cycle floor(n·LINE_INC / 2^FRAC_W) − 1, so the mean line length is LINE_INC / 2^FRAC_W clocks.
- R2: `line_num` is 0 after reset. It changes only in the cycle after a tick, and then it goes up by one unless R3 applies.
- R3: A tick taken while `line_num` ≥ total − 1 sets `line_num` to 0. The total is LINES_60HZ (263) when `std50_sel` = 0 and LINES_50HZ (313) when `std50_sel` = 1. This rule also covers a line number left above the new total after the standard changes.
- R4: `vblank_irq` is a one-cycle pulse. It is high in exactly the cycle in which `line_num` first becomes VBL_LINE (240).
- R5: `vblank_active` is high exactly while `line_num` ≥ VBL_LINE.
- R6: `frame_count` goes up by one in the same cycle as `vblank_irq` and holds its value in every other cycle.
- R7: `field_odd` changes only in a `vblank_irq` cycle. In that cycle it takes bit 0 of the new `frame_count` if `ilace_mode` was 2'b11 on the clock edge that advanced the frame. For any other `ilace_mode` value it takes 0.
- R8: `audio_tick` is high with every AUDIO_LINES-th hsync tick, counted from reset without a break across frame wraps.
- R9: While `rst_n` is low, all outputs are 0. This holds whenever reset is applied, including in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| std50_sel | input | 1 | 0: 60 Hz line total, 1: 50 Hz line total |
| ilace_mode | input | 2 | Interlace mode bits; the field toggles only when both are set |
| hsync_tick | output | 1 | One-clock pulse at the end of each scanline |
| audio_tick | output | 1 | One-clock pulse on every AUDIO_LINES-th scanline end |
| line_num | output | LINE_W | Current scanline number |
| vblank_active | output | 1 | High while the line number is at or above the blanking line |
| vblank_irq | output | 1 | One-clock vertical-blank interrupt pulse |
| frame_count | output | FRAME_W | Frame counter, advanced at vertical blank |
| field_odd | output | 1 | Odd/even field status bit |

## Verification
The audio divider and the vertical-blank event both run from the same hsync tick, so an audio tick can land in the same cycle as the tick that starts the blanking interrupt. The bench sets the audio interval to 16, which makes the 240th tick both the blanking tick and an audio tick. It also crosses several frame wraps in each standard, so audio ticks meet line-counter wraps. The bench predicts every output in every cycle. Tick times come from a closed-form floor division of the cycle index, not from a copy of the accumulator. The bench therefore judges each coincident cycle by requiring each event to appear together with the others and with no shift in any of them. It also switches from the 50 Hz total to the 60 Hz total while the line number is already past 262, which checks the wrap rule when the counter is above the new total.

// File: rtl/tg_pkg.sv
package tg_pkg;

   typedef logic [1:0] ilace_t;

   // Both interlace bits set: the field bit follows the frame counter.
   localparam ilace_t ILACE_BOTH = 2'b11;

   typedef enum logic {
      STD_60HZ = 1'b0,
      STD_50HZ = 1'b1
   } std_e;

   function automatic logic field_after(input ilace_t mode, input logic frame_lsb);
      return (mode == ILACE_BOTH) ? frame_lsb : 1'b0;
   endfunction

endpackage

// File: rtl/tg_frac_pacer.sv
// Fractional line pacer: the length of each line is the integer part of
// (carried remainder + increment); the fraction carries to the next line.
module tg_frac_pacer #(
   parameter int                 INC_W    = 32,
   parameter int                 FRAC_W   = 12,
   parameter logic [INC_W-1:0]   LINE_INC = 32'd8791293
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int                PER_W = INC_W - FRAC_W + 1;
   localparam logic [FRAC_W-1:0] REM0  = LINE_INC[FRAC_W-1:0];
   localparam logic [PER_W-1:0]  PER0  = PER_W'(LINE_INC >> FRAC_W);
   localparam logic [PER_W-1:0]  CNT0  = PER0 - 1'b1;

   logic [FRAC_W-1:0] rem_q;
   logic [PER_W-1:0]  cnt_q;
   logic [INC_W:0]    sum;
   logic [PER_W-1:0]  period;

   always_comb begin
      sum    = {{(INC_W + 1 - FRAC_W){1'b0}}, rem_q} + {1'b0, LINE_INC};
      period = sum[INC_W:FRAC_W];
   end

   assign tick = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= REM0;
         cnt_q <= CNT0;
      end else if (tick) begin
         rem_q <= sum[FRAC_W-1:0];
         cnt_q <= period - 1'b1;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/tg_line_ctr.sv
// Scanline counter with standard-dependent wrap and the blanking event.
module tg_line_ctr #(
   parameter int LINE_W     = 9,
   parameter int LINES_60HZ = 263,
   parameter int LINES_50HZ = 313,
   parameter int VBL_LINE   = 240
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  tg_pkg::std_e      std_sel,
   output logic [LINE_W-1:0] line,
   output logic              vbl_event,
   output logic              vblank_active,
   output logic              vblank_irq
);
   localparam logic [LINE_W-1:0] LAST_60 = LINE_W'(LINES_60HZ - 1);
   localparam logic [LINE_W-1:0] LAST_50 = LINE_W'(LINES_50HZ - 1);
   localparam logic [LINE_W-1:0] VBL_PRE = LINE_W'(VBL_LINE - 1);
   localparam logic [LINE_W-1:0] VBL_AT  = LINE_W'(VBL_LINE);

   logic [LINE_W-1:0] line_q;
   logic [LINE_W-1:0] last_line;
   logic              at_end;
   logic              irq_q;

   always_comb begin
      last_line = (std_sel == tg_pkg::STD_50HZ) ? LAST_50 : LAST_60;
      at_end    = (line_q >= last_line);
      vbl_event = tick && !at_end && (line_q == VBL_PRE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= vbl_event;
         if (tick) line_q <= at_end ? '0 : line_q + 1'b1;
      end
   end

   assign line          = line_q;
   assign vblank_active = (line_q >= VBL_AT);
   assign vblank_irq    = irq_q;
endmodule

// File: rtl/tg_line_divider.sv
// Divides the hsync tick stream; pulses on every DIV-th tick.
module tg_line_divider #(
   parameter int DIV = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic pulse
);
   localparam int  CNT_W   = (DIV > 2) ? $clog2(DIV) : 1;
   localparam bit  IS_POW2 = ((DIV & (DIV - 1)) == 0);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (IS_POW2) begin : g_pow2
         // Natural wrap of the counter marks the interval.
         assign pulse = tick && (&cnt_q);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt_q <= '0;
            else if (tick) cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_cmp
         localparam logic [CNT_W-1:0] TOP = CNT_W'(DIV - 1);
         assign pulse = tick && (cnt_q == TOP);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt_q <= '0;
            else if (tick) cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/tg_frame_field.sv
// Frame counter and odd/even field bit, both advanced at vertical blank.
module tg_frame_field #(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               vbl_event,
   input  tg_pkg::ilace_t     ilace_mode,
   output logic [FRAME_W-1:0] frame_count,
   output logic               field_odd
);
   logic [FRAME_W-1:0] frame_q;
   logic [FRAME_W-1:0] frame_nxt;
   logic               field_q;

   assign frame_nxt = frame_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '0;
         field_q <= 1'b0;
      end else if (vbl_event) begin
         frame_q <= frame_nxt;
         field_q <= tg_pkg::field_after(ilace_mode, frame_nxt[0]);
      end
   end

   assign frame_count = frame_q;
   assign field_odd   = field_q;
endmodule

// File: rtl/scanline_timing_gen.sv
module scanline_timing_gen #(
   parameter int               INC_W       = 32,
   parameter int               FRAC_W      = 12,
   parameter logic [INC_W-1:0] LINE_INC    = 32'd8791293,
   parameter int               LINE_W      = 9,
   parameter int               LINES_60HZ  = 263,
   parameter int               LINES_50HZ  = 313,
   parameter int               VBL_LINE    = 240,
   parameter int               AUDIO_LINES = 32,
   parameter int               FRAME_W     = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               std50_sel,
   input  logic [1:0]         ilace_mode,
   output logic               hsync_tick,
   output logic               audio_tick,
   output logic [LINE_W-1:0]  line_num,
   output logic               vblank_active,
   output logic               vblank_irq,
   output logic [FRAME_W-1:0] frame_count,
   output logic               field_odd
);
   localparam int MIN_LINES = (LINES_60HZ < LINES_50HZ) ? LINES_60HZ : LINES_50HZ;
   localparam int MAX_LINES = (LINES_60HZ > LINES_50HZ) ? LINES_60HZ : LINES_50HZ;

   // Elaboration-time parameter checks
   generate
      if (FRAC_W < 1 || FRAC_W >= INC_W) begin : g_bad_frac
         $error("FRAC_W must lie in 1..INC_W-1");
      end
      if ((LINE_INC >> FRAC_W) == 0) begin : g_bad_inc
         $error("LINE_INC must give at least one clock per line");
      end
      if (MAX_LINES > (1 << LINE_W)) begin : g_bad_linew
         $error("LINE_W too narrow for the line totals");
      end
      if (VBL_LINE < 1 || VBL_LINE >= MIN_LINES) begin : g_bad_vbl
         $error("VBL_LINE must lie inside both frames");
      end
      if (AUDIO_LINES < 2) begin : g_bad_aud
         $error("AUDIO_LINES must be at least 2");
      end
      if (FRAME_W < 1) begin : g_bad_frame
         $error("FRAME_W must be at least 1");
      end
   endgenerate

   logic         tick;
   logic         vbl_event;
   tg_pkg::std_e std_sel;

   assign std_sel = tg_pkg::std_e'(std50_sel);

   tg_frac_pacer #(
      .INC_W    (INC_W),
      .FRAC_W   (FRAC_W),
      .LINE_INC (LINE_INC)
   ) u_pacer (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   tg_line_ctr #(
      .LINE_W     (LINE_W),
      .LINES_60HZ (LINES_60HZ),
      .LINES_50HZ (LINES_50HZ),
      .VBL_LINE   (VBL_LINE)
   ) u_lines (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick          (tick),
      .std_sel       (std_sel),
      .line          (line_num),
      .vbl_event     (vbl_event),
      .vblank_active (vblank_active),
      .vblank_irq    (vblank_irq)
   );

   tg_line_divider #(
      .DIV (AUDIO_LINES)
   ) u_audio (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .pulse (audio_tick)
   );

   tg_frame_field #(
      .FRAME_W (FRAME_W)
   ) u_frame (
      .clk         (clk),
      .rst_n       (rst_n),
      .vbl_event   (vbl_event),
      .ilace_mode  (ilace_mode),
      .frame_count (frame_count),
      .field_odd   (field_odd)
   );

   assign hsync_tick = tick;
endmodule

// File: rtl/scanline_timing_gen_chk.sv
module scanline_timing_gen_chk #(
   parameter int LINE_W     = 9,
   parameter int LINES_60HZ = 263,
   parameter int LINES_50HZ = 313,
   parameter int VBL_LINE   = 240,
   parameter int FRAME_W    = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               std50_sel,
   input logic [1:0]         ilace_mode,
   input logic               hsync_tick,
   input logic               audio_tick,
   input logic [LINE_W-1:0]  line_num,
   input logic               vblank_active,
   input logic               vblank_irq,
   input logic [FRAME_W-1:0] frame_count,
   input logic               field_odd
);
   logic [LINE_W-1:0] last_line;
   assign last_line = std50_sel ? LINE_W'(LINES_50HZ - 1) : LINE_W'(LINES_60HZ - 1);

   p_line_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !hsync_tick |=> $stable(line_num));

   p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hsync_tick && line_num < last_line) |=> line_num == $past(line_num) + 1'b1);

   p_line_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hsync_tick && line_num >= last_line) |=> line_num == '0);

   p_irq_at_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hsync_tick && line_num == LINE_W'(VBL_LINE - 1)) |=>
      (vblank_irq && line_num == LINE_W'(VBL_LINE)));

   p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      vblank_irq |=> !vblank_irq);

   p_vact_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vblank_active) |-> vblank_irq);

   p_frame_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vblank_irq |-> frame_count == FRAME_W'($past(frame_count) + 1'b1));

   p_frame_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !vblank_irq |-> $stable(frame_count));

   p_field_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (vblank_irq && $past(ilace_mode) != 2'b11) |-> !field_odd);

   p_field_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (vblank_irq && $past(ilace_mode) == 2'b11) |-> field_odd == frame_count[0]);

   p_field_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !vblank_irq |-> $stable(field_odd));

   p_audio_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      audio_tick |-> hsync_tick);
endmodule

bind scanline_timing_gen scanline_timing_gen_chk #(
   .LINE_W     (LINE_W),
   .LINES_60HZ (LINES_60HZ),
   .LINES_50HZ (LINES_50HZ),
   .VBL_LINE   (VBL_LINE),
   .FRAME_W    (FRAME_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .std50_sel     (std50_sel),
   .ilace_mode    (ilace_mode),
   .hsync_tick    (hsync_tick),
   .audio_tick    (audio_tick),
   .line_num      (line_num),
   .vblank_active (vblank_active),
   .vblank_irq    (vblank_irq),
   .frame_count   (frame_count),
   .field_odd     (field_odd)
);

// File: tb/sim_scanline_timing_gen.sv
module sim_scanline_timing_gen;
   localparam int          CLK_PERIOD = 10;
   localparam int          FRAC_W     = 12;
   localparam logic [31:0] LINE_INC   = 32'd83285;   // about 20.33 clocks per line
   localparam int          AUD_LINES  = 16;          // tick 240 is also an audio tick
   localparam int          LINE_W     = 9;
   localparam int          FRAME_W    = 16;
   localparam int          VBL        = 240;
   localparam int          L60        = 263;
   localparam int          L50        = 313;
   localparam int          NPH        = 5;
   // Phase table: standard select, interlace bits, cycles to run
   localparam logic        PH_STD [NPH] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
   localparam logic [1:0]  PH_ILC [NPH] = '{2'b11, 2'b01, 2'b11, 2'b10, 2'b11};
   localparam int          PH_LEN [NPH] = '{12000, 6000, 14000, 7000, 6000};

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               std50_sel = 1'b0;
   logic [1:0]         ilace_mode = 2'b00;
   logic               hsync_tick, audio_tick, vblank_active, vblank_irq, field_odd;
   logic [LINE_W-1:0]  line_num;
   logic [FRAME_W-1:0] frame_count;

   int     n_checks = 0;
   int     n_fail   = 0;
   longint cyc      = 0;
   int     m_line   = 0;
   int     m_frame  = 0;
   bit     m_field  = 1'b0;
   bit     m_irq    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   scanline_timing_gen #(
      .INC_W (32), .FRAC_W (FRAC_W), .LINE_INC (LINE_INC), .LINE_W (LINE_W),
      .LINES_60HZ (L60), .LINES_50HZ (L50), .VBL_LINE (VBL),
      .AUDIO_LINES (AUD_LINES), .FRAME_W (FRAME_W)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .std50_sel (std50_sel), .ilace_mode (ilace_mode),
      .hsync_tick (hsync_tick), .audio_tick (audio_tick), .line_num (line_num),
      .vblank_active (vblank_active), .vblank_irq (vblank_irq),
      .frame_count (frame_count), .field_odd (field_odd)
   );

   task automatic check(input string tag, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
      end
   endtask

   // Ticks seen in cycles 0..c: the n-th lands in cycle floor(n*INC/2^F)-1 (R1)
   function automatic longint ticks_thru(input longint c);
      return ((c + 2) * (longint'(1) << FRAC_W) - 1) / longint'(LINE_INC);
   endfunction

   task automatic check_reset_state();
      check("R9 line_num", line_num, 0);
      check("R9 frame_count", frame_count, 0);
      check("R9 field_odd", field_odd, 0);
      check("R9 vblank_irq", vblank_irq, 0);
      check("R9 vblank_active", vblank_active, 0);
      check("R9 hsync_tick", hsync_tick, 0);
      check("R9 audio_tick", audio_tick, 0);
   endtask

   // One cycle: compare all outputs, then apply inputs and advance the model.
   task automatic step(input logic s50, input logic [1:0] ilc);
      bit     et;
      longint tnow;
      int     last;
      tnow = ticks_thru(cyc);
      et   = (tnow > ticks_thru(cyc - 1));
      check("R1 hsync_tick", hsync_tick, et);
      check("R8 audio_tick", audio_tick, et && (tnow % AUD_LINES == 0));
      check("R2 line_num", line_num, m_line);
      check("R5 vblank_active", vblank_active, m_line >= VBL);
      check("R4 vblank_irq", vblank_irq, m_irq);
      check("R6 frame_count", frame_count, m_frame);
      check("R7 field_odd", field_odd, m_field);
      std50_sel  = s50;
      ilace_mode = ilc;
      last  = (s50 ? L50 : L60) - 1;
      m_irq = 1'b0;
      if (et) begin
         if (m_line == VBL - 1) begin
            m_irq   = 1'b1;
            m_frame = (m_frame + 1) % (1 << FRAME_W);
            m_field = (ilc == 2'b11) ? m_frame[0] : 1'b0;
         end
         m_line = (m_line >= last) ? 0 : m_line + 1;
      end
      @(posedge clk);
      @(negedge clk);
      cyc++;
   endtask

   task automatic release_reset();
      rst_n   = 1'b1;
      cyc     = 0;
      m_line  = 0;
      m_frame = 0;
      m_field = 1'b0;
      m_irq   = 1'b0;
   endtask

   initial begin : watchdog
      #(longint'(CLK_PERIOD) * 200000);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check_reset_state();                       // R9 at power-up
      release_reset();

      // Table walk: every output is predicted in every cycle
      for (int p = 0; p < NPH; p++) begin
         for (int k = 0; k < PH_LEN[p]; k++) step(PH_STD[p], PH_ILC[p]);
      end

      // R3: leave the 50 Hz frame above line 262, then select 60 Hz
      while (m_line != 300) step(1'b1, 2'b11);
      step(1'b0, 2'b11);
      while (m_line == 300) step(1'b0, 2'b11);
      check("R3 wrap from above new total", line_num, 0);
      for (int k = 0; k < 3000; k++) step(1'b0, 2'b11);

      // R9: reset in the middle of a frame, then restart the timeline
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check_reset_state();
      release_reset();
      // R4/R8 coincidence: tick 240 is both the blanking tick and an audio tick
      for (int k = 0; k < 6000; k++) step(1'b0, 2'b00);
      check("R6 frame after restart", frame_count, 1);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule